// File: doc/BRIEF.md
# Shift and Rotate End-Condition Controller

This block sets the bits that enter and leave the two ends of two eight-bit shifters. One shifter sits in front of the register-file write port and holds the high word. The other sits on the Q register and holds the low word. A direction bit and a two-bit end-mode field are sampled once per cycle. Together they select one of four end treatments, in either direction:

- zero fill;
- a rotate of each word on its own;
- a 16-bit shift across both words;
- a 16-bit rotate across both words.

A per-shifter shift qualifier from the destination decode says whether that shifter moves at all.

Each shifter has an MSB end line and an LSB end line. On a shift toward the MSB, the LSB line carries a bit into the word, and the word pushes its old MSB out. On a shift toward the LSB the roles swap. The block does not use high-impedance nets. For every end line it gives a value and a drive enable, and the enable is low when the controller must not drive that line. It also gives the bit that each shifter pushes out. The control fields are registered at the clock edge. The word boundary bits pass straight through to the outputs within the cycle, because they settle late in the cycle.

Top module: `shend_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next output state has every drive enable, line value and shift-out bit at 0.
- R2: `dir_up`, `end_mode`, `ram_shift` and `q_shift` take effect only after the rising edge that samples them. The four word-boundary inputs affect the outputs in the same cycle, with no clock edge needed.
- R3: A shifter whose qualifier was sampled low has both of its drive enables at 0, both of its line values at 0, and a shift-out bit of 0.
- R4: For an active shifter, `dir_up`=1 (toward the MSB) drives the LSB line only, and `dir_up`=0 drives the MSB line only.
- R5: `end_mode`=2'b00 puts 0 on the driven line of every active shifter.
- R6: `end_mode`=2'b01 feeds each word's own opposite end bit into it. Toward the MSB, LSB fill = own MSB. Toward the LSB, MSB fill = own LSB.
- R7: `end_mode`=2'b10 joins the words into one 16-bit shift. Toward the MSB: register-file LSB = Q MSB, and Q LSB = 0. Toward the LSB: Q MSB = register-file LSB, and register-file MSB = 0.
- R8: `end_mode`=2'b11 joins the words into one 16-bit rotate. Toward the MSB: register-file LSB = Q MSB, and Q LSB = register-file MSB. Toward the LSB: Q MSB = register-file LSB, and register-file MSB = Q LSB.
- R9: The shift-out bit of an active shifter is its MSB when `dir_up`=1 and its LSB when `dir_up`=0.
- R10: No shifter ever has both of its end lines driven at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_up | input | 1 | 1 = shift toward MSB, 0 = toward LSB |
| end_mode | input | 2 | End treatment: 00 zero, 01 own rotate, 10 double shift, 11 double rotate |
| ram_shift | input | 1 | Register-file shifter is shifting this cycle |
| q_shift | input | 1 | Q shifter is shifting this cycle |
| ram_msb | input | 1 | MSB of the register-file word |
| ram_lsb | input | 1 | LSB of the register-file word |
| q_msb | input | 1 | MSB of the Q word |
| q_lsb | input | 1 | LSB of the Q word |
| ram_msb_line | output | 1 | Value for the register-file MSB end line |
| ram_msb_drv | output | 1 | Drive enable, register-file MSB end line |
| ram_lsb_line | output | 1 | Value for the register-file LSB end line |
| ram_lsb_drv | output | 1 | Drive enable, register-file LSB end line |
| q_msb_line | output | 1 | Value for the Q MSB end line |
| q_msb_drv | output | 1 | Drive enable, Q MSB end line |
| q_lsb_line | output | 1 | Value for the Q LSB end line |
| q_lsb_drv | output | 1 | Drive enable, Q LSB end line |
| ram_sout | output | 1 | Bit pushed out of the register-file word |
| q_sout | output | 1 | Bit pushed out of the Q word |

## Verification
Every end mode is applied in both directions with word-boundary bits chosen so that the own-word source, the partner-word source and the constant zero all give different values. This separates a rotate from a cross-word link, and a zero fill from a missing one. Runs with only one qualifier set show that the idle shifter stays silent while its partner still uses the idle word's boundary bits. A latency run changes the control between edges and a boundary bit within a cycle. It tells the registered path apart from the pass-through path.

// File: rtl/shend_pkg.sv
// Package: shared types for the shift end-condition controller.
// Assumes index 0 is the high (register-file) word and index 1 the low (Q) word.
package shend_pkg;
    localparam int N_SHIFTERS = 2;
    localparam int MODE_W     = 2;

    typedef enum logic [MODE_W-1:0] {
        END_ZERO    = 2'b00,
        END_ROT     = 2'b01,
        END_DSHIFT  = 2'b10,
        END_DROT    = 2'b11
    } end_mode_e;

    typedef struct packed {
        logic                  up;
        end_mode_e             mode;
        logic [N_SHIFTERS-1:0] act;
    } shend_ctl_t;
endpackage

// File: rtl/shend_ctl_reg.sv
// Module: holds the sampled control word for one cycle.
// Assumes a synchronous active-low reset; the reset value is "no shifter active".
module shend_ctl_reg
    import shend_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  shend_ctl_t ctl_d,
    output shend_ctl_t ctl_q
);
    // Purpose: capture the control fields at each edge, or clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{up: 1'b0, mode: END_ZERO, act: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/shend_fill.sv
// Module: end-line logic for one shifter.
// It picks the fill bit for the vacated end, sets the drive enables and gives
// the bit pushed out. LOW_HALF=1 marks the low word of a 16-bit pair.
// Assumes the partner inputs come from the other word's boundary bits.
module shend_fill
    import shend_pkg::*;
#(
    parameter bit LOW_HALF = 1'b0
) (
    input  logic      active,
    input  logic      up,
    input  end_mode_e mode,
    input  logic      own_msb,
    input  logic      own_lsb,
    input  logic      mate_msb,
    input  logic      mate_lsb,
    output logic      msb_line,
    output logic      msb_drv,
    output logic      lsb_line,
    output logic      lsb_drv,
    output logic      sout
);
    logic lsb_fill;
    logic msb_fill;

    // Purpose: choose the bit entering the LSB on a shift toward the MSB.
    always_comb begin
        unique case (mode)
            END_ZERO:   lsb_fill = 1'b0;
            END_ROT:    lsb_fill = own_msb;
            END_DSHIFT: lsb_fill = LOW_HALF ? 1'b0 : mate_msb;
            END_DROT:   lsb_fill = mate_msb;
            default:    lsb_fill = 1'b0;
        endcase
    end

    // Purpose: choose the bit entering the MSB on a shift toward the LSB.
    always_comb begin
        unique case (mode)
            END_ZERO:   msb_fill = 1'b0;
            END_ROT:    msb_fill = own_lsb;
            END_DSHIFT: msb_fill = LOW_HALF ? mate_lsb : 1'b0;
            END_DROT:   msb_fill = mate_lsb;
            default:    msb_fill = 1'b0;
        endcase
    end

    // Purpose: enable only the input end of an active shifter and gate the values.
    always_comb begin
        lsb_drv  = active & up;
        msb_drv  = active & ~up;
        lsb_line = lsb_drv & lsb_fill;
        msb_line = msb_drv & msb_fill;
        sout     = active & (up ? own_msb : own_lsb);
    end
endmodule

// File: rtl/shend_ctrl.sv
// Module: top of the shift end-condition controller.
// It registers the control fields, then builds the end-line logic for the
// register-file shifter (high word, index 0) and the Q shifter (low word,
// index 1). The two shifters are cross-linked through their partner bits.
// Assumes the boundary bits settle within the cycle and are used unregistered.
module shend_ctrl
    import shend_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_up,
    input  logic [1:0] end_mode,
    input  logic       ram_shift,
    input  logic       q_shift,
    input  logic       ram_msb,
    input  logic       ram_lsb,
    input  logic       q_msb,
    input  logic       q_lsb,
    output logic       ram_msb_line,
    output logic       ram_msb_drv,
    output logic       ram_lsb_line,
    output logic       ram_lsb_drv,
    output logic       q_msb_line,
    output logic       q_msb_drv,
    output logic       q_lsb_line,
    output logic       q_lsb_drv,
    output logic       ram_sout,
    output logic       q_sout
);
    localparam int LAST = N_SHIFTERS - 1;

    shend_ctl_t            ctl_d;
    shend_ctl_t            ctl_q;
    logic [N_SHIFTERS-1:0] w_msb, w_lsb;
    logic [N_SHIFTERS-1:0] o_msb_line, o_msb_drv, o_lsb_line, o_lsb_drv, o_sout;

    // Purpose: pack the control inputs into the control word.
    always_comb begin
        ctl_d.up   = dir_up;
        ctl_d.mode = end_mode_e'(end_mode);
        ctl_d.act  = {q_shift, ram_shift};
    end

    shend_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_d (ctl_d),
        .ctl_q (ctl_q)
    );

    // Purpose: index the word boundary bits by shifter.
    always_comb begin
        w_msb = {q_msb, ram_msb};
        w_lsb = {q_lsb, ram_lsb};
    end

    for (genvar g = 0; g < N_SHIFTERS; g++) begin : g_sh
        shend_fill #(.LOW_HALF(g == LAST)) u_fill (
            .active   (ctl_q.act[g]),
            .up       (ctl_q.up),
            .mode     (ctl_q.mode),
            .own_msb  (w_msb[g]),
            .own_lsb  (w_lsb[g]),
            .mate_msb (w_msb[LAST-g]),
            .mate_lsb (w_lsb[LAST-g]),
            .msb_line (o_msb_line[g]),
            .msb_drv  (o_msb_drv[g]),
            .lsb_line (o_lsb_line[g]),
            .lsb_drv  (o_lsb_drv[g]),
            .sout     (o_sout[g])
        );
    end

    // Purpose: map the per-shifter results onto the named ports.
    always_comb begin
        ram_msb_line = o_msb_line[0];
        ram_msb_drv  = o_msb_drv[0];
        ram_lsb_line = o_lsb_line[0];
        ram_lsb_drv  = o_lsb_drv[0];
        ram_sout     = o_sout[0];
        q_msb_line   = o_msb_line[LAST];
        q_msb_drv    = o_msb_drv[LAST];
        q_lsb_line   = o_lsb_line[LAST];
        q_lsb_drv    = o_lsb_drv[LAST];
        q_sout       = o_sout[LAST];
    end
endmodule

// File: rtl/shend_ctrl_chk.sv
// Module: assertion checker for shend_ctrl, attached by bind.
// Assumes it sees only the top-level ports.
module shend_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_up,
    input logic [1:0] end_mode,
    input logic       ram_shift,
    input logic       q_shift,
    input logic       ram_msb,
    input logic       ram_lsb,
    input logic       q_msb,
    input logic       q_lsb,
    input logic       ram_msb_line,
    input logic       ram_msb_drv,
    input logic       ram_lsb_line,
    input logic       ram_lsb_drv,
    input logic       q_msb_line,
    input logic       q_msb_drv,
    input logic       q_lsb_line,
    input logic       q_lsb_drv,
    input logic       ram_sout,
    input logic       q_sout
);
    // R10: never both ends of a shifter driven
    p_one_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_msb_drv && ram_lsb_drv) && !(q_msb_drv && q_lsb_drv));

    // R3: an idle Q shifter stays silent
    p_idle_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(q_shift)) |->
            (!q_msb_drv && !q_lsb_drv && !q_msb_line && !q_lsb_line && !q_sout));

    // R4: direction picks the driven end
    p_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ram_shift)) |-> (ram_lsb_drv == $past(dir_up)));

    // R8: double rotate toward the MSB links the words
    p_drot_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ram_shift) && $past(q_shift) && $past(dir_up)
         && ($past(end_mode) == 2'b11)) |->
            (ram_lsb_line == q_msb) && (q_lsb_line == ram_msb));

    // R9: shift-out toward the LSB is the word LSB
    p_sout_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ram_shift) && !$past(dir_up)) |-> (ram_sout == ram_lsb));
endmodule

bind shend_ctrl shend_ctrl_chk i_chk (.*);

// File: tb/test_shend_ctrl.sv
module test_shend_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_up = 1'b0;
    logic [1:0] end_mode = 2'b00;
    logic       ram_shift = 1'b0, q_shift = 1'b0;
    logic       ram_msb = 1'b0, ram_lsb = 1'b0, q_msb = 1'b0, q_lsb = 1'b0;
    logic       ram_msb_line, ram_msb_drv, ram_lsb_line, ram_lsb_drv;
    logic       q_msb_line, q_msb_drv, q_lsb_line, q_lsb_drv, ram_sout, q_sout;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;

    always #5 clk = ~clk;

    shend_ctrl i_shend_ctrl (.*);

    // stimulus {dir, mode[1:0], ram_shift, q_shift, ram_msb, ram_lsb, q_msb, q_lsb}
    localparam int NV = 14;
    localparam logic [8:0] STIM [NV] = '{
        9'b1_00_11_1111, 9'b0_00_11_1111, 9'b1_01_11_1001, 9'b0_01_11_0110,
        9'b1_10_11_0010, 9'b0_10_11_1100, 9'b1_11_11_1000, 9'b0_11_11_0001,
        9'b1_11_11_0010, 9'b1_01_00_1111, 9'b1_11_10_1010, 9'b0_11_01_0101,
        9'b1_10_11_1101, 9'b0_01_11_0000 };
    // expected {rmd, rml, rld, rll, qmd, qml, qld, qll, ram_sout, q_sout}
    localparam logic [9:0] EXP [NV] = '{
        10'b0010001011, 10'b1000100011, 10'b0011001010, 10'b1100100010,
        10'b0011001001, 10'b1000110010, 10'b0010001110, 10'b1100100001,
        10'b0011001001, 10'b0000000000, 10'b0011000010, 10'b0000110001,
        10'b0010001010, 10'b1000100000 };

    function automatic string tag_of(int i);
        case (i)
            0, 1:   return "R5 R4 R9";
            2, 3:   return "R6 R9";
            4, 5:   return "R7";
            6, 7:   return "R8";
            8:      return "R8";
            9:      return "R3";
            10, 11: return "R3 R8";
            12:     return "R7";
            default: return "R6 R10";
        endcase
    endfunction

    function automatic logic [9:0] outs();
        return {ram_msb_drv, ram_msb_line, ram_lsb_drv, ram_lsb_line,
                q_msb_drv, q_msb_line, q_lsb_drv, q_lsb_line, ram_sout, q_sout};
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply(logic [8:0] s);
        {dir_up, end_mode, ram_shift, q_shift, ram_msb, ram_lsb, q_msb, q_lsb} = s;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with active control on the inputs
        apply(STIM[0]);
        repeat (3) @(posedge clk);
        #2 check("R1 reset state", outs(), 10'b0);

        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) apply(STIM[i]);
            @(posedge clk);
            #2 check(tag_of(i), outs(), EXP[i]);
            // R10: one driven end per shifter
            check("R10 one end", {2'b0, ram_msb_drv & ram_lsb_drv, 7'b0, q_msb_drv & q_lsb_drv}, 10'b0);
        end

        // R2: control waits for an edge; boundary bits pass at once
        @(negedge clk) apply(9'b1_01_11_0000);
        @(posedge clk);
        #2 check("R2 rotate loaded", outs(), 10'b0010001000);
        @(negedge clk) begin
            apply(9'b0_00_00_1000);
        end
        #1 check("R2 control held, data live", outs(), 10'b0011001010);
        @(posedge clk);
        #2 check("R2 control taken", outs(), 10'b0);

        // R1: reset mid-run clears an active state
        @(negedge clk) apply(STIM[6]);
        @(posedge clk);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #2 check("R1 reset clears", outs(), 10'b0);
        @(negedge clk) rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule